// File: doc/BRIEF.md
# Serial Audio Frame Receiver

This block takes a three-wire serial audio stream (a bit clock, a word-select line and a data line) and turns it into a parallel left and right sample pair. All three lines are brought into the system clock domain through two-flop synchronisers. The chosen bit-clock edge is detected there, and a strobe is made for every active edge. A word-select transition in the configured direction marks the start of a frame. The transition the other way marks the start of the right half. A per-half bit counter places each received bit, MSB first, at its slot in a sample register whose width is set at run time.

Static configuration inputs choose three things. The first is which word-select direction starts a frame. The second is which bit-clock edge samples the lines. The third is whether bit 0 of each half is the bit taken on the very edge that sees the word-select change, or the bit taken one edge later. When a frame ends, which is the bit-0 edge of the next frame, the finished pair is presented with a one-cycle valid pulse. Configuration must only change while the block is held in reset. The bit clock must run at no more than a quarter of the system clock.

Top module: `aud_rx_top`

## Requirements
- R1: With `cfg_start_hi`=1, a low-to-high word-select change starts a frame and the high level carries the left half. With `cfg_start_hi`=0, a high-to-low change starts it and the low level carries the left half.
- R2: With `cfg_fall_edge`=0, word select and data are sampled on rising bit-clock edges. With `cfg_fall_edge`=1, they are sampled on falling edges.
- R3: With `cfg_early`=0, bit 0 of a half is the bit sampled on the active edge after the edge that sees the word-select change. The bit taken on that change edge still belongs to the half before.
- R4: With `cfg_early`=1, bit 0 of a half is the bit sampled on the same active edge that sees the word-select change.
- R5: Bits arrive MSB first. The sample width is W = `cfg_width_m1`+1, from 1 to 32. Each output sample is right-aligned: bit position p of a half lands at output bit W-1-p, and output bits W and above are zero.
- R6: Bits at positions W and beyond within a half are ignored and do not alter the sample.
- R7: If a half carries fewer than W bits, the missing low-order bits are zero.
- R8: `pair_valid` is a single-cycle pulse, given once for each frame whose start and right half were both received. It is given on the bit-0 edge of the following frame. No pulse is given for a frame whose start was not seen. The sample outputs hold their value between pulses.
- R9: `pair_valid` and the new samples appear on the third rising system-clock edge after the bit-clock pin transition that forms the next frame's bit-0 edge.
- R10: After reset, `pair_valid` is 0, both samples are 0, and the block waits for a frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial bit clock (asynchronous) |
| ws | input | 1 | Word select (asynchronous) |
| sd | input | 1 | Serial data (asynchronous) |
| cfg_start_hi | input | 1 | 1: rising word select starts a frame; 0: falling |
| cfg_fall_edge | input | 1 | 0: sample on rising bit clock; 1: on falling |
| cfg_early | input | 1 | 1: bit 0 is taken on the transition edge itself |
| cfg_width_m1 | input | WSEL_W | Sample width minus one |
| left_sample | output | MAX_W | Right-aligned left sample |
| right_sample | output | MAX_W | Right-aligned right sample |
| pair_valid | output | 1 | One-cycle pulse when a pair is complete |

## Verification
A pair becomes due exactly three system clocks after the driver moves the bit-clock pin to the active level that forms the next frame's bit-0 edge. In normal mode that is the edge after the word-select change; in early mode it is the change edge itself. The driver stamps each expected pair with this due cycle when it makes that edge. The monitor compares the data and the arrival cycle on the pulse, so a pair that arrives early, late or twice is caught. Inputs change on the falling system-clock edge and outputs are read there too, well clear of the sampling edge.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

    // Number of flops in each line synchroniser.
    localparam int unsigned SYNC_STAGES = 2;

    // Which half of the frame is being collected.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LEFT  = 2'd1,
        PH_RIGHT = 2'd2
    } half_e;

    // Static receive configuration.
    typedef struct packed {
        logic start_hi;   // direction of the frame-start word-select change
        logic fall_edge;  // sample on the falling bit-clock edge
        logic early;      // bit 0 on the transition edge itself
    } rx_cfg_t;

    // Line values captured on one active edge.
    typedef struct packed {
        logic ws;
        logic sd;
    } line_smp_t;

    // Half boundaries seen on an edge.
    typedef struct packed {
        logic start;
        logic mid;
    } bound_t;

    function automatic bound_t classify_ws(input logic start_hi,
                                           input logic prev,
                                           input logic cur);
        bound_t b;
        b.start = (prev != cur) && (cur == start_hi);
        b.mid   = (prev != cur) && (cur != start_hi);
        return b;
    endfunction

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= '0;
                else     chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/aud_rx_edge.sv
module aud_rx_edge (
    input  logic clk,
    input  logic rst,
    input  logic sck_s,
    input  logic fall_edge,
    output logic strobe
);
    logic sck_d;

    always_ff @(posedge clk) begin
        if (rst) sck_d <= 1'b0;
        else     sck_d <= sck_s;
    end

    assign strobe = fall_edge ? (sck_d & ~sck_s) : (sck_s & ~sck_d);

    // Active edges can never come on back-to-back system clocks.
    AST_STROBE_SPACED: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe); // R2
endmodule

// File: rtl/aud_rx_framer.sv
module aud_rx_framer
    import aud_rx_pkg::*;
#(
    parameter int unsigned MAX_W  = 32,
    parameter int unsigned WSEL_W = $clog2(MAX_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  line_smp_t         smp,
    input  rx_cfg_t           cfg,
    input  logic [WSEL_W-1:0] width_m1,
    output logic [MAX_W-1:0]  out_left,
    output logic [MAX_W-1:0]  out_right,
    output logic              out_valid
);
    localparam int unsigned CW = $clog2(MAX_W + 1);
    localparam logic [CW-1:0] POS_SAT = CW'(MAX_W);

    logic             ws_prev;
    logic             primed;
    bound_t           pend;
    half_e            phase;
    logic [CW-1:0]    bitpos;
    logic [MAX_W-1:0] acc_l;
    logic [MAX_W-1:0] acc_r;

    bound_t seen;
    bound_t act;

    // Write one bit at its slot; positions beyond the width are dropped.
    function automatic logic [MAX_W-1:0] put_bit(input logic [MAX_W-1:0]  acc,
                                                 input logic [CW-1:0]     pos,
                                                 input logic [WSEL_W-1:0] wm1,
                                                 input logic              b);
        logic [MAX_W-1:0] r;
        r = acc;
        if (int'(pos) <= int'(wm1))
            r[int'(wm1) - int'(pos)] = b;
        return r;
    endfunction

    always_comb begin
        seen = primed ? classify_ws(cfg.start_hi, ws_prev, smp.ws) : '0;
        act  = cfg.early ? seen : pend;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ws_prev   <= 1'b0;
            primed    <= 1'b0;
            pend      <= '0;
            phase     <= PH_IDLE;
            bitpos    <= '0;
            acc_l     <= '0;
            acc_r     <= '0;
            out_left  <= '0;
            out_right <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (strobe) begin
                ws_prev <= smp.ws;
                primed  <= 1'b1;
                pend    <= cfg.early ? bound_t'('0) : seen;
                if (act.start) begin
                    if (phase == PH_RIGHT) begin
                        out_left  <= acc_l;
                        out_right <= acc_r;
                        out_valid <= 1'b1;
                    end
                    phase  <= PH_LEFT;
                    acc_l  <= put_bit('0, '0, width_m1, smp.sd);
                    bitpos <= CW'(1);
                end else if (act.mid && phase == PH_LEFT) begin
                    phase  <= PH_RIGHT;
                    acc_r  <= put_bit('0, '0, width_m1, smp.sd);
                    bitpos <= CW'(1);
                end else if (phase == PH_LEFT) begin
                    acc_l  <= put_bit(acc_l, bitpos, width_m1, smp.sd);
                    bitpos <= (bitpos == POS_SAT) ? bitpos : bitpos + CW'(1);
                end else if (phase == PH_RIGHT) begin
                    acc_r  <= put_bit(acc_r, bitpos, width_m1, smp.sd);
                    bitpos <= (bitpos == POS_SAT) ? bitpos : bitpos + CW'(1);
                end
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid); // R8

    AST_HOLD_PAIR: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_left) && $stable(out_right))); // R8

    AST_ZERO_ABOVE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (((out_left >> (int'(width_m1) + 1)) == '0) &&
                       ((out_right >> (int'(width_m1) + 1)) == '0))); // R5

    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(strobe)); // R9
endmodule

// File: rtl/aud_rx_top.sv
module aud_rx_top
    import aud_rx_pkg::*;
#(
    parameter int unsigned MAX_W  = 32,
    parameter int unsigned WSEL_W = $clog2(MAX_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck,
    input  logic              ws,
    input  logic              sd,
    input  logic              cfg_start_hi,
    input  logic              cfg_fall_edge,
    input  logic              cfg_early,
    input  logic [WSEL_W-1:0] cfg_width_m1,
    output logic [MAX_W-1:0]  left_sample,
    output logic [MAX_W-1:0]  right_sample,
    output logic              pair_valid
);
    logic [2:0] lines_s;
    logic       strobe;
    line_smp_t  smp;
    rx_cfg_t    cfg;

    assign cfg.start_hi  = cfg_start_hi;
    assign cfg.fall_edge = cfg_fall_edge;
    assign cfg.early     = cfg_early;

    aud_rx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sck, ws, sd}),
        .q   (lines_s)
    );

    assign smp.ws = lines_s[1];
    assign smp.sd = lines_s[0];

    aud_rx_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .sck_s     (lines_s[2]),
        .fall_edge (cfg.fall_edge),
        .strobe    (strobe)
    );

    aud_rx_framer #(.MAX_W(MAX_W), .WSEL_W(WSEL_W)) u_framer (
        .clk       (clk),
        .rst       (rst),
        .strobe    (strobe),
        .smp       (smp),
        .cfg       (cfg),
        .width_m1  (cfg_width_m1),
        .out_left  (left_sample),
        .out_right (right_sample),
        .out_valid (pair_valid)
    );
endmodule

// File: tb/aud_rx_top_tb.sv
module aud_rx_top_tb;
    localparam int MAX_W = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst = 1'b1;
    logic        sck = 1'b0, ws = 1'b0, sd = 1'b0;
    logic        pol = 1'b1, fe = 1'b0, early = 1'b0;
    logic [4:0]  wm1 = 5'd15;
    logic [31:0] left_o, right_o;
    logic        valid_o;

    aud_rx_top #(.MAX_W(MAX_W)) u_dut (
        .clk(clk), .rst(rst), .sck(sck), .ws(ws), .sd(sd),
        .cfg_start_hi(pol), .cfg_fall_edge(fe), .cfg_early(early),
        .cfg_width_m1(wm1),
        .left_sample(left_o), .right_sample(right_o), .pair_valid(valid_o)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [31:0] l;
        logic [31:0] r;
        int          due;
        string       tag;
    } exp_t;
    exp_t q[$];

    logic        it_lvl   [0:255];
    logic        it_bit   [0:255];
    int          it_frame [0:255];
    logic [31:0] fl [0:3];
    logic [31:0] fr [0:3];

    function automatic logic [31:0] expect_val(input logic [31:0] v, input int n, input int w);
        logic [63:0] t;
        if (n >= w) t = {32'b0, v} >> (n - w);
        else        t = {32'b0, v} << (w - n);
        t = t & ((64'd1 << w) - 64'd1);
        return t[31:0];
    endfunction

    function automatic logic [31:0] gen(input int c, input int f, input int n);
        logic [63:0] m;
        logic [31:0] v;
        v = 32'hA5C3_0F1E ^ (32'(c) * 32'h9E37_79B9) ^ (32'(f) * 32'h85EB_CA6B);
        v = {v[12:0], v[31:13]} ^ 32'h1234_5678;
        m = (64'd1 << n) - 64'd1;
        return v & m[31:0];
    endfunction

    // Scoreboard monitor
    logic prev_v = 1'b0;
    always @(negedge clk) begin
        if (rst) begin
            prev_v = 1'b0;
        end else begin
            if (valid_o) begin
                exp_t e;
                if (prev_v) begin
                    n_tests++; n_fail++;
                    $display("FAIL R8 valid wider than one cycle: actual=2+ expected=1");
                end
                if (q.size() == 0) begin
                    n_tests++; n_fail++;
                    $display("FAIL R8 unexpected pair: actual L=%h R=%h expected none", left_o, right_o);
                end else begin
                    e = q.pop_front();
                    n_tests++;
                    if (left_o !== e.l || right_o !== e.r) begin
                        n_fail++;
                        $display("FAIL %s pair data: actual L=%h R=%h expected L=%h R=%h",
                                 e.tag, left_o, right_o, e.l, e.r);
                    end
                    n_tests++;
                    if (cyc != e.due) begin
                        n_fail++;
                        $display("FAIL R9 latency: actual cycle=%0d expected cycle=%0d", cyc, e.due);
                    end
                end
            end
            prev_v = valid_o;
        end
    end

    // One sampled bit: inactive edge with new line values, then the active edge.
    task automatic tick(input logic wv, input logic dv, input bit push, input exp_t e);
        exp_t ee;
        ee = e;
        @(negedge clk);
        sck = fe ? 1'b1 : 1'b0;
        ws  = wv;
        sd  = dv;
        repeat (4) @(negedge clk);
        sck = fe ? 1'b0 : 1'b1;
        if (push) begin
            ee.due = cyc + 3;
            q.push_back(ee);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic run_case(input int c, input int n, input int w, input logic p,
                            input logic f, input logic e, input string tag);
        int k;
        exp_t ex;
        pol = p; fe = f; early = e; wm1 = 5'(w - 1);
        sck = f ? 1'b1 : 1'b0;
        ws = ~p; sd = 1'b0;
        rst = 1'b1;
        q.delete();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R10: reset state
        n_tests++;
        if (valid_o !== 1'b0 || left_o !== '0 || right_o !== '0) begin
            n_fail++;
            $display("FAIL R10 reset state: actual v=%b L=%h R=%h expected 0 0 0",
                     valid_o, left_o, right_o);
        end
        // Build the item list: idle, three frames, closing frame start
        k = 0;
        for (int i = 0; i < 2; i++) begin
            it_lvl[k] = ~p; it_bit[k] = 1'b0; it_frame[k] = -1; k++;
        end
        for (int fi = 0; fi < 3; fi++) begin
            fl[fi] = gen(c, 2 * fi, n);
            fr[fi] = gen(c, 2 * fi + 1, n);
            for (int b = 0; b < n; b++) begin
                it_lvl[k] = p; it_bit[k] = fl[fi][n-1-b];
                it_frame[k] = (b == 0) ? fi : -1; k++;
            end
            for (int b = 0; b < n; b++) begin
                it_lvl[k] = ~p; it_bit[k] = fr[fi][n-1-b]; it_frame[k] = -1; k++;
            end
        end
        for (int i = 0; i < 2; i++) begin
            it_lvl[k] = p; it_bit[k] = 1'b0; it_frame[k] = (i == 0) ? 3 : -1; k++;
        end
        // Drive
        for (int i = 0; i < k; i++) begin
            logic dv;
            int bnd;
            dv  = early ? it_bit[i] : ((i == 0) ? 1'b0 : it_bit[i-1]);
            bnd = early ? it_frame[i] : ((i == 0) ? -1 : it_frame[i-1]);
            ex.tag = tag;
            ex.due = 0;
            if (bnd >= 1) begin
                ex.l = expect_val(fl[bnd-1], n, w);
                ex.r = expect_val(fr[bnd-1], n, w);
            end else begin
                ex.l = '0; ex.r = '0;
            end
            tick(it_lvl[i], dv, bnd >= 1, ex);
        end
        repeat (8) @(negedge clk);
        // R8: every complete frame delivered exactly once
        n_tests++;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R8 missing pairs: actual pending=%0d expected 0", q.size());
        end
    endtask

    initial begin
        run_case(1, 16, 16, 1'b1, 1'b0, 1'b0, "R3");  // normal mode bit 0
        run_case(2, 16, 16, 1'b1, 1'b0, 1'b1, "R4");  // early mode
        run_case(3, 16, 16, 1'b0, 1'b0, 1'b0, "R1");  // falling start
        run_case(4, 16, 16, 1'b0, 1'b1, 1'b1, "R2");  // falling bit clock
        run_case(5, 24, 16, 1'b1, 1'b1, 1'b0, "R6");  // extra bits dropped
        run_case(6,  8, 16, 1'b1, 1'b0, 1'b1, "R7");  // zero fill
        run_case(7, 32, 32, 1'b0, 1'b0, 1'b0, "R5");  // full width
        run_case(8,  3,  1, 1'b1, 1'b1, 1'b1, "R6");  // one-bit width
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL R9 watchdog: actual cycles=%0d expected < 150000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule